// File: doc/BRIEF.md
# Local Exclusive Reservation Monitor

This block keeps a single load-linked/store-conditional reservation for one processor core. When the core issues an exclusive load, the block records the target granule and the access size, then arms the reservation. When the core issues an exclusive store, the block checks that request against the armed reservation and returns a one-bit status one cycle later. A status of 0 grants the store and a status of 1 refuses it. The memory write is not done here. The core, or the memory path, uses the status to commit or drop the write.

Every exclusive store uses up the reservation, whether it passes or fails. A clear input drops the reservation on events such as exception entry or a context switch. Because of this, a store-conditional that was interrupted fails and the software loop retries, so the code does not deadlock. A parameter selects whether an ordinary store from the same core to the reserved granule also drops the reservation.

Top module: `excl_monitor`

## Requirements
- R1: After reset the monitor is open (unarmed), and no response is valid.
- R2: An exclusive load (kind 2'b01) arms the reservation and records the address granule and the size. An exclusive load while armed replaces the recorded granule and size.
- R3: An exclusive store (kind 2'b10) produces rsp_valid_o=1 in the next cycle, with rsp_fail_o=0 only if the monitor was armed and both the granule and the size match. rsp_valid_o is 0 in every other cycle.
- R4: Address bits below GRANULE_LOG2 are ignored in the match, so an exclusive store anywhere in the reserved granule matches.
- R5: A size mismatch or a granule mismatch makes the store fail (status 1).
- R6: Every exclusive store disarms the monitor, so a second exclusive store without an exclusive load in between fails.
- R7: clear_i drops the reservation. If clear_i comes in the same cycle as an exclusive store, that store fails.
- R8: An exclusive load in the same cycle as clear_i leaves the monitor armed with the new granule and size.
- R9: When CLR_ON_STORE=1, a plain store (kind 2'b11) to the reserved granule disarms the monitor. A plain store to another granule, or a plain load (kind 2'b00), has no effect on the reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_kind_i | input | 2 | 00 load, 01 excl load, 10 excl store, 11 store |
| req_addr_i | input | ADDR_W | Request byte address |
| req_size_i | input | SIZE_W | Access size code (log2 bytes) |
| clear_i | input | 1 | Drop reservation (exception entry, context switch) |
| rsp_valid_o | output | 1 | Status valid, one cycle after an exclusive store |
| rsp_fail_o | output | 1 | Status: 0 success, 1 failure |

## Verification
The bench targets the cases where a reservation might wrongly survive: a second exclusive store back to back, a clear in the same cycle as an exclusive store, and a plain store into the reserved granule. A design that gets any of these wrong reports success where failure is expected. The bench also checks stores to other bytes of the same granule and stores with a changed size. A comparison that used full addresses would refuse the first, and one that ignored size would grant the second. Random mixed traffic, including clears that coincide with exclusive loads, is compared against a bench model of the reservation. A design that lets the clear win over the new load would then fail a later store that should succeed.

// File: rtl/excl_monitor_pkg.sv
package excl_monitor_pkg;
  typedef enum logic [1:0] {
    KIND_LD    = 2'b00,
    KIND_LDEX  = 2'b01,
    KIND_STEX  = 2'b10,
    KIND_ST    = 2'b11
  } req_kind_e;

  typedef enum logic {
    MON_OPEN = 1'b0,
    MON_EXCL = 1'b1
  } mon_state_e;
endpackage

// File: rtl/excl_req_decode.sv
module excl_req_decode
  import excl_monitor_pkg::*;
(
  input  logic       req_valid_i,
  input  logic [1:0] req_kind_i,
  output logic       ldex_o,
  output logic       stex_o,
  output logic       st_o
);
  always_comb begin
    ldex_o = 1'b0;
    stex_o = 1'b0;
    st_o   = 1'b0;
    if (req_valid_i) begin
      unique case (req_kind_e'(req_kind_i))
        KIND_LDEX: ldex_o = 1'b1;
        KIND_STEX: stex_o = 1'b1;
        KIND_ST:   st_o   = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/excl_match.sv
module excl_match #(
  parameter int ADDR_W       = 32,
  parameter int SIZE_W       = 2,
  parameter int GRANULE_LOG2 = 4,
  localparam int TAG_W       = ADDR_W - GRANULE_LOG2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [TAG_W-1:0]  rsv_tag_i,
  input  logic [SIZE_W-1:0] rsv_size_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic              tag_hit_o,
  output logic              full_hit_o
);
  assign tag_o      = addr_i[ADDR_W-1:GRANULE_LOG2];
  assign tag_hit_o  = (tag_o == rsv_tag_i);
  assign full_hit_o = tag_hit_o && (size_i == rsv_size_i);
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_monitor_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int SIZE_W       = 2,
  parameter int GRANULE_LOG2 = 4,
  parameter bit CLR_ON_STORE = 1'b1,
  localparam int TAG_W       = ADDR_W - GRANULE_LOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic              clear_i,
  output logic              rsp_valid_o,
  output logic              rsp_fail_o
);
  mon_state_e        state_q, state_d;
  logic [TAG_W-1:0]  rsv_tag_q;
  logic [SIZE_W-1:0] rsv_size_q;
  logic              ldex, stex, st;
  logic [TAG_W-1:0]  req_tag;
  logic              tag_hit, full_hit;
  logic              st_kill;

  excl_req_decode u_dec (
    .req_valid_i(req_valid_i),
    .req_kind_i (req_kind_i),
    .ldex_o     (ldex),
    .stex_o     (stex),
    .st_o       (st)
  );

  excl_match #(
    .ADDR_W      (ADDR_W),
    .SIZE_W      (SIZE_W),
    .GRANULE_LOG2(GRANULE_LOG2)
  ) u_match (
    .addr_i    (req_addr_i),
    .size_i    (req_size_i),
    .rsv_tag_i (rsv_tag_q),
    .rsv_size_i(rsv_size_q),
    .tag_o     (req_tag),
    .tag_hit_o (tag_hit),
    .full_hit_o(full_hit)
  );

  generate
    if (CLR_ON_STORE) begin : g_st_clr
      assign st_kill = st && tag_hit;
    end else begin : g_st_keep
      assign st_kill = 1'b0;
    end
  endgenerate

  // exclusive load wins over clear; everything else drops the reservation
  always_comb begin
    state_d = state_q;
    if (ldex)                           state_d = MON_EXCL;
    else if (clear_i || stex || st_kill) state_d = MON_OPEN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= MON_OPEN;
      rsv_tag_q   <= '0;
      rsv_size_q  <= '0;
      rsp_valid_o <= 1'b0;
      rsp_fail_o  <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_o <= stex;
      if (stex) rsp_fail_o <= !((state_q == MON_EXCL) && full_hit && !clear_i);
      if (ldex) begin
        rsv_tag_q  <= req_tag;
        rsv_size_q <= req_size_i;
      end
    end
  end
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        req_kind_i,
  input logic              clear_i,
  input logic              rsp_valid_o,
  input logic              rsp_fail_o
);
  logic stex_now;
  assign stex_now = req_valid_i && (req_kind_i == 2'b10);

  // R3
  rsp_follows_stex_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stex_now |=> rsp_valid_o);

  // R3
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stex_now |=> !rsp_valid_o);

  // R6
  back_to_back_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stex_now && !(req_valid_i && req_kind_i == 2'b01)) ##1 stex_now |=> rsp_fail_o);

  // R7
  clear_same_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stex_now && clear_i) |=> rsp_fail_o);

  // R7
  clear_before_stex_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !(req_valid_i && req_kind_i == 2'b01)) ##1 stex_now |=> rsp_fail_o);
endmodule

bind excl_monitor excl_monitor_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_kind_i (req_kind_i),
  .clear_i    (clear_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_fail_o (rsp_fail_o)
);

// File: tb/excl_monitor_test.sv
`timescale 1ns/1ps
module excl_monitor_test;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 2;
  localparam int GL = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_kind = 0;
  logic [ADDR_W-1:0] req_addr = 0;
  logic [SIZE_W-1:0] req_size = 0;
  logic clear = 0;
  logic rsp_valid, rsp_fail;

  int n_tests = 0, n_fail = 0;

  // model
  bit m_armed = 0;
  logic [ADDR_W-GL-1:0] m_tag = 0;
  logic [SIZE_W-1:0] m_size = 0;

  always #2.5 clk = ~clk;

  excl_monitor #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .GRANULE_LOG2(GL), .CLR_ON_STORE(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_addr_i(req_addr), .req_size_i(req_size), .clear_i(clear),
    .rsp_valid_o(rsp_valid), .rsp_fail_o(rsp_fail));

  task automatic check(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic bit model_expect_fail(logic [ADDR_W-1:0] a, logic [SIZE_W-1:0] s, bit clr);
    return !(m_armed && a[ADDR_W-1:GL] == m_tag && s == m_size && !clr);
  endfunction

  function automatic void model_step(bit v, logic [1:0] k, logic [ADDR_W-1:0] a,
                                     logic [SIZE_W-1:0] s, bit clr);
    bit ldex = v && k == 2'b01;
    bit stex = v && k == 2'b10;
    bit kill = v && k == 2'b11 && a[ADDR_W-1:GL] == m_tag;
    if (ldex) begin m_armed = 1; m_tag = a[ADDR_W-1:GL]; m_size = s; end
    else if (clr || stex || kill) m_armed = 0;
  endfunction

  // drive one cycle at negedge; sample response at next negedge
  task automatic op(bit v, logic [1:0] k, logic [ADDR_W-1:0] a, logic [SIZE_W-1:0] s,
                    bit clr, string req);
    bit is_stex, expf;
    is_stex = v && k == 2'b10;
    expf = model_expect_fail(a, s, clr);
    req_valid = v; req_kind = k; req_addr = a; req_size = s; clear = clr;
    model_step(v, k, a, s, clr);
    @(negedge clk);
    req_valid = 0; clear = 0;
    check({req, " rsp_valid"}, rsp_valid, is_stex);
    if (is_stex) check({req, " status"}, rsp_fail, expf);
  endtask

  initial begin
    #20000000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    check("R1 rsp_valid reset", rsp_valid, 1'b0);
    rst_n = 1;
    @(negedge clk);
    // R1: store-exclusive while open fails
    op(1, 2'b10, 32'h100, 2, 0, "R1");
    // R2/R3: pair succeeds
    op(1, 2'b01, 32'h100, 2, 0, "R2");
    op(1, 2'b10, 32'h100, 2, 0, "R3");
    // R6: second store-exclusive fails
    op(1, 2'b10, 32'h100, 2, 0, "R6");
    // R4: other byte same granule
    op(1, 2'b01, 32'h200, 1, 0, "R4");
    op(1, 2'b10, 32'h20C, 1, 0, "R4");
    // R5: size and granule mismatch
    op(1, 2'b01, 32'h200, 1, 0, "R5");
    op(1, 2'b10, 32'h200, 2, 0, "R5");
    op(1, 2'b01, 32'h200, 1, 0, "R5");
    op(1, 2'b10, 32'h210, 1, 0, "R5");
    // R2: reload replaces
    op(1, 2'b01, 32'h300, 3, 0, "R2");
    op(1, 2'b01, 32'h400, 3, 0, "R2");
    op(1, 2'b10, 32'h300, 3, 0, "R2");
    // R7: clear before and same cycle
    op(1, 2'b01, 32'h500, 0, 0, "R7");
    op(0, 2'b00, 32'h0, 0, 1, "R7");
    op(1, 2'b10, 32'h500, 0, 0, "R7");
    op(1, 2'b01, 32'h500, 0, 0, "R7");
    op(1, 2'b10, 32'h500, 0, 1, "R7");
    // R8: load with clear stays armed
    op(1, 2'b01, 32'h600, 2, 1, "R8");
    op(1, 2'b10, 32'h604, 2, 0, "R8");
    // R9: plain store into granule kills; elsewhere and plain load don't
    op(1, 2'b01, 32'h700, 2, 0, "R9");
    op(1, 2'b11, 32'h708, 2, 0, "R9");
    op(1, 2'b10, 32'h700, 2, 0, "R9");
    op(1, 2'b01, 32'h700, 2, 0, "R9");
    op(1, 2'b11, 32'h800, 2, 0, "R9");
    op(1, 2'b00, 32'h700, 2, 0, "R9");
    op(1, 2'b10, 32'h700, 2, 0, "R9");
    // random mix over a few granules
    for (int i = 0; i < 3000; i++) begin
      logic [ADDR_W-1:0] a;
      a = {26'd0, 2'($urandom_range(0, 3)), 4'($urandom)};
      op($urandom_range(0, 7) != 0, 2'($urandom), a, 2'($urandom_range(0, 1)),
         $urandom_range(0, 9) == 0, "R3 random");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule